// File: doc/BRIEF.md
# Fault Response and Retry Sequencer

This block decides what happens to a power stage's output enable when one of several fault sources becomes active. Each source comes with its own 8-bit response word, supplied in parallel. The word tells the sequencer what to do with that source. It can only note the fault. It can switch the output off for good. It can switch the output off, wait a programmable delay and try again a limited or unlimited number of times. Or it can hold the output off until the fault goes away and then resume. Delays are counted in pulses of a millisecond tick input, and a parameter table turns each delay code into a tick count.

A single sequencer serves all sources. When several sources are active in the same cycle, the block resolves them in a fixed order of severity. Among competing retry requests the smallest retry count wins, and the retry budget that is left after earlier attempts also takes part in that minimum. A latched flag per source records every fault seen. Reading the flags through the read strobe clears them. Flag generation, the serial bus and register storage sit outside the block.

Top module: `fault_resp_seq`

## Requirements
- R1: Each response word is split into an action in bits [7:6], a retry count in bits [5:3] and a delay code in bits [2:0]. Action 00 means ignore: the fault is only recorded in its flag and the output enable stays 1.
- R2: Flag bit i is set in any cycle where fault i is active, and it stays set until a cycle with the read strobe high. That read cycle clears the bit, unless fault i is active in the same cycle.
- R3: Action 01 drives the output enable to 0 from the clock edge that samples the fault. The latched-off output goes to 1 and both stay there, whatever the fault does, until the external clear.
- R4: Action 11 holds the output enable at 0 while the fault is active. The enable returns to 1 on the first clock edge that samples no hold, latch or retry fault.
- R5: Action 10 drives the output enable to 0 and loads delay table entry D, selected by the delay code. After D tick pulses the enable returns to 1 on the next clock edge.
- R6: A retry count n in 0..6 allows n re-enables. The trip that follows them latches the output off, so a count of 0 latches on the first trip. The remaining budget is kept across trips until the external clear.
- R7: A retry count of 7 retries without limit and never causes the latched-off state.
- R8: When retry faults trip together, the smallest retry count among them is used, taken together with any remaining budget. The delay code comes from the lowest-numbered of those faults.
- R9: If faults with different actions are active in the same cycle, action 01 wins over 10, and 10 wins over 11.
- R10: A one-cycle external clear leaves the latched-off state, sets the output enable to 1 and restores the full retry budget.
- R11: After reset the output enable is 1, all flags are 0 and the latched-off output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle pulse per delay time unit |
| fault_i | input | N_FAULT | Fault levels, active high |
| resp_i | input | 8*N_FAULT | Response words, word i in bits [8i+7:8i] |
| rd_clr_i | input | 1 | Flag read strobe, clears flags |
| clear_i | input | 1 | External clear of latched-off state and retry budget |
| out_en_o | output | 1 | Output enable for the power stage |
| flags_o | output | N_FAULT | Latched fault flags |
| latched_off_o | output | 1 | Output latched off until clear |

## Verification
The hardest case to reach from the ports is a retry budget that is partly used when a new retry source arrives with a larger count. The block has to merge the count that is left with the new field, not restart from the new field. The stimulus trips two retry sources together, lets the delay run out, then trips only the source with the larger count. It then counts how many re-enables happen before the output latches off. Delay lengths are swept over all eight codes, and retry counts over all values, each with its expected number of ticks and trips worked out arithmetically.

// File: rtl/fault_seq_pkg.sv
package fault_seq_pkg;
   localparam int WORD_W  = 8;
   localparam int RETRY_W = 3;
   localparam int DCODE_W = 3;
   localparam int NUM_DLY = 1 << DCODE_W;
   localparam logic [RETRY_W-1:0] RETRY_FOREVER = '1;

   typedef enum logic [1:0] {
      ACT_IGNORE = 2'b00,
      ACT_LATCH  = 2'b01,
      ACT_RETRY  = 2'b10,
      ACT_HOLD   = 2'b11
   } act_e;

   typedef enum logic [1:0] {
      ST_RUN,
      ST_HOLD,
      ST_WAIT,
      ST_LATCH
   } seq_st_e;

   typedef struct packed {
      act_e               act;
      logic [RETRY_W-1:0] retries;
      logic [DCODE_W-1:0] dly;
   } resp_word_t;
endpackage

// File: rtl/fault_resp_resolve.sv
module fault_resp_resolve
   import fault_seq_pkg::*;
#(
   parameter int N_FAULT = 4
) (
   input  logic [N_FAULT-1:0]        fault_i,
   input  logic [N_FAULT*WORD_W-1:0] resp_i,
   output logic                      any_latch_o,
   output logic                      any_retry_o,
   output logic                      any_hold_o,
   output logic [RETRY_W-1:0]        min_retry_o,
   output logic [DCODE_W-1:0]        dly_code_o
);
   logic [N_FAULT-1:0] latch_v, retry_v, hold_v;
   logic [RETRY_W-1:0] retry_f [N_FAULT];
   logic [DCODE_W-1:0] dly_f   [N_FAULT];

   for (genvar g = 0; g < N_FAULT; g++) begin : g_dec
      resp_word_t w;
      assign w          = resp_word_t'(resp_i[g*WORD_W +: WORD_W]);
      assign latch_v[g] = fault_i[g] && (w.act == ACT_LATCH);
      assign retry_v[g] = fault_i[g] && (w.act == ACT_RETRY);
      assign hold_v[g]  = fault_i[g] && (w.act == ACT_HOLD);
      assign retry_f[g] = w.retries;
      assign dly_f[g]   = w.dly;
   end

   assign any_latch_o = |latch_v;
   assign any_retry_o = |retry_v;
   assign any_hold_o  = |hold_v;

   // smallest retry count; delay code of the lowest-numbered retry source
   always_comb begin
      min_retry_o = RETRY_FOREVER;
      dly_code_o  = '0;
      for (int i = N_FAULT - 1; i >= 0; i--) begin
         if (retry_v[i]) begin
            if (retry_f[i] < min_retry_o) min_retry_o = retry_f[i];
            dly_code_o = dly_f[i];
         end
      end
   end

   // R8: the chosen count never exceeds any active retry field
   always_comb begin
      for (int i = 0; i < N_FAULT; i++) begin
         if (retry_v[i]) begin
            p_min_pick_r8: assert (min_retry_o <= retry_f[i])
               else $error("resolved retry count above an active field");
         end
      end
   end
endmodule

// File: rtl/fault_delay_timer.sv
module fault_delay_timer
   import fault_seq_pkg::*;
#(
   parameter int                              TICK_W    = 16,
   parameter logic [NUM_DLY-1:0][TICK_W-1:0]  DLY_TICKS = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [DCODE_W-1:0] code_i,
   input  logic               tick_i,
   output logic               done_o
);
   if (TICK_W < 1) begin : g_bad_w
      $error("TICK_W must be at least 1");
   end

   logic [TICK_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load_i)                 cnt_q <= DLY_TICKS[code_i];
      else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   // R5: the count only moves on a load or a tick
   p_cnt_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fault_resp_seq.sv
module fault_resp_seq
   import fault_seq_pkg::*;
#(
   parameter int                             N_FAULT   = 4,
   parameter int                             TICK_W    = 16,
   parameter logic [NUM_DLY-1:0][TICK_W-1:0] DLY_TICKS = {16'd2000, 16'd1000, 16'd500, 16'd250,
                                                          16'd100,  16'd50,   16'd20,  16'd10}
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ms_tick_i,
   input  logic [N_FAULT-1:0]        fault_i,
   input  logic [N_FAULT*WORD_W-1:0] resp_i,
   input  logic                      rd_clr_i,
   input  logic                      clear_i,
   output logic                      out_en_o,
   output logic [N_FAULT-1:0]        flags_o,
   output logic                      latched_off_o
);
   if (N_FAULT < 1) begin : g_bad_n
      $error("N_FAULT must be at least 1");
   end

   logic               any_latch, any_retry, any_hold, tmr_done, tmr_load;
   logic [RETRY_W-1:0] min_r, eff_r, left_q, left_d;
   logic [DCODE_W-1:0] dly_code;
   logic               armed_q, armed_d;
   logic [N_FAULT-1:0] flags_q;
   seq_st_e            st_q, st_d;

   fault_resp_resolve #(.N_FAULT(N_FAULT)) i_resolve (
      .fault_i     (fault_i),
      .resp_i      (resp_i),
      .any_latch_o (any_latch),
      .any_retry_o (any_retry),
      .any_hold_o  (any_hold),
      .min_retry_o (min_r),
      .dly_code_o  (dly_code)
   );

   fault_delay_timer #(.TICK_W(TICK_W), .DLY_TICKS(DLY_TICKS)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .code_i (dly_code),
      .tick_i (ms_tick_i),
      .done_o (tmr_done)
   );

   // budget in force: fresh count, or the smaller of what is left and the new count
   assign eff_r = (armed_q && left_q < min_r) ? left_q : min_r;

   always_comb begin
      st_d     = st_q;
      left_d   = left_q;
      armed_d  = clear_i ? 1'b0 : armed_q;
      tmr_load = 1'b0;
      unique case (st_q)
         ST_RUN, ST_HOLD: begin
            if (any_latch) begin
               st_d = ST_LATCH;
            end else if (any_retry) begin
               if (eff_r == '0) begin
                  st_d = ST_LATCH;
               end else begin
                  st_d     = ST_WAIT;
                  tmr_load = 1'b1;
                  armed_d  = 1'b1;
                  left_d   = (eff_r == RETRY_FOREVER) ? eff_r : eff_r - 1'b1;
               end
            end else if (any_hold) begin
               st_d = ST_HOLD;
            end else begin
               st_d = ST_RUN;
            end
         end
         ST_WAIT: begin
            if (any_latch)     st_d = ST_LATCH;
            else if (tmr_done) st_d = ST_RUN;
         end
         ST_LATCH: begin
            if (clear_i) st_d = ST_RUN;
         end
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         left_q  <= '0;
         armed_q <= 1'b0;
         flags_q <= '0;
      end else begin
         st_q    <= st_d;
         left_q  <= left_d;
         armed_q <= armed_d;
         flags_q <= (rd_clr_i ? '0 : flags_q) | fault_i;
      end
   end

   assign out_en_o      = (st_q == ST_RUN);
   assign latched_off_o = (st_q == ST_LATCH);
   assign flags_o       = flags_q;

   // R3: the latched-off state is left only through the clear
   p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LATCH && !clear_i) |=> (st_q == ST_LATCH));

   // R2: without a read strobe no flag bit falls
   p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   // R6: an armed budget never grows before a clear
   p_budget_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !clear_i) |=> (left_q <= $past(left_q)));

   // R4: hold releases once no blocking fault is sampled
   p_hold_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD && !any_hold && !any_latch && !any_retry) |=> out_en_o);
endmodule

// File: tb/test_fault_resp_seq.sv
module test_fault_resp_seq;
   localparam int NF = 3;
   localparam int TW = 8;

   function automatic logic [7:0][TW-1:0] mk_tbl();
      logic [7:0][TW-1:0] t;
      for (int c = 0; c < 8; c++) t[c] = TW'(2 * c + 1);
      return t;
   endfunction

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [NF-1:0] fault = '0;
   logic [NF*8-1:0] resp = '0;
   logic          rd_clr = 1'b0;
   logic          clr = 1'b0;
   logic          out_en, lo;
   logic [NF-1:0] flags;
   int            nvec = 0;
   int            nbad = 0;

   fault_resp_seq #(.N_FAULT(NF), .TICK_W(TW), .DLY_TICKS(mk_tbl())) i_fault_resp_seq (
      .clk(clk), .rst_n(rst_n), .ms_tick_i(tick), .fault_i(fault), .resp_i(resp),
      .rd_clr_i(rd_clr), .clear_i(clr), .out_en_o(out_en), .flags_o(flags),
      .latched_off_o(lo)
   );

   always #10 clk = ~clk;

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic setw(input int idx, input logic [1:0] a, input logic [2:0] r, input logic [2:0] d);
      resp[idx*8 +: 8] = {a, r, d};
   endtask

   task automatic pulse_fault(input logic [NF-1:0] f);
      fault = f; cyc(1); fault = '0;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin tick = 1'b1; cyc(1); end
      tick = 1'b0;
   endtask

   task automatic do_clear();
      clr = 1'b1; cyc(1); clr = 1'b0;
   endtask

   task automatic do_read();
      rd_clr = 1'b1; cyc(1); rd_clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      cyc(3); rst_n = 1'b1; cyc(1);
      // R11 reset state
      chk("R11 out_en", out_en, 1); chk("R11 flags", flags, 0); chk("R11 latched", lo, 0);

      // R1 ignore action records only
      setw(0, 2'b00, 3'd0, 3'd0);
      fault = 3'b001;
      for (int k = 0; k < 3; k++) begin cyc(1); chk("R1 ignore out_en", out_en, 1); end
      chk("R1 flag set", flags, 3'b001);
      fault = '0; cyc(2);
      chk("R2 flag sticky", flags, 3'b001);
      do_read();
      chk("R2 read clears", flags, 0);
      fault = 3'b001; cyc(1); rd_clr = 1'b1; cyc(1); rd_clr = 1'b0;
      chk("R2 read with active fault keeps bit", flags, 3'b001);
      fault = '0; do_read();

      // R3 latch off until clear
      setw(1, 2'b01, 3'd3, 3'd0);
      pulse_fault(3'b010);
      chk("R3 out_en off", out_en, 0); chk("R3 latched", lo, 1);
      ticks(4); cyc(3);
      chk("R3 still off", out_en, 0); chk("R3 still latched", lo, 1);
      do_clear();
      chk("R10 clear enables", out_en, 1); chk("R10 clear unlatches", lo, 0);

      // R4 hold while active
      setw(2, 2'b11, 3'd0, 3'd0);
      fault = 3'b100;
      for (int k = 0; k < 4; k++) begin cyc(1); chk("R4 held off", out_en, 0); end
      fault = '0; cyc(1);
      chk("R4 resumes", out_en, 1); chk("R4 not latched", lo, 0);

      // R5 delay sweep, unlimited retries (R7)
      for (int c = 0; c < 8; c++) begin
         setw(0, 2'b10, 3'd7, 3'(c));
         pulse_fault(3'b001);
         chk("R5 off after trip", out_en, 0);
         ticks(2 * c + 1);
         chk("R5 off after last tick", out_en, 0);
         cyc(1);
         chk("R5 back on after delay", out_en, 1);
         chk("R7 never latched", lo, 0);
      end

      // R6 retry budget sweep
      for (int n = 0; n < 7; n++) begin
         do_clear();
         setw(0, 2'b10, 3'(n), 3'd0);
         for (int k = 1; k <= n + 1; k++) begin
            pulse_fault(3'b001);
            chk("R6 off after trip", out_en, 0);
            chk("R6 latch on final trip", lo, (k == n + 1) ? 1 : 0);
            if (k <= n) begin
               ticks(1); cyc(1);
               chk("R6 re-enabled", out_en, 1);
            end
         end
         ticks(3); cyc(2);
         chk("R6 stays latched", lo, 1);
      end
      do_clear();

      // R7 many trips with unlimited retries
      setw(0, 2'b10, 3'd7, 3'd0);
      for (int k = 0; k < 20; k++) begin pulse_fault(3'b001); ticks(1); cyc(1); end
      chk("R7 on after 20 trips", out_en, 1); chk("R7 no latch", lo, 0);

      // R8 simultaneous retry sources
      do_clear();
      setw(0, 2'b10, 3'd5, 3'd2);
      setw(1, 2'b10, 3'd2, 3'd1);
      pulse_fault(3'b011);
      ticks(4);
      chk("R8 delay from lowest source", out_en, 0);
      ticks(1); cyc(1);
      chk("R8 on after 5 ticks", out_en, 1);
      pulse_fault(3'b001);
      chk("R8 second trip not latched", lo, 0);
      ticks(5); cyc(1);
      chk("R8 second re-enable", out_en, 1);
      pulse_fault(3'b001);
      chk("R8 min budget exhausted", lo, 1);
      do_clear();

      // R9 priority
      setw(0, 2'b11, 3'd0, 3'd0);
      setw(1, 2'b01, 3'd0, 3'd0);
      setw(2, 2'b10, 3'd7, 3'd0);
      pulse_fault(3'b111);
      chk("R9 latch wins", lo, 1);
      do_clear();
      pulse_fault(3'b101);
      cyc(1);
      chk("R9 retry over hold", out_en, 0);
      chk("R9 not latched", lo, 0);
      ticks(1); cyc(1);
      chk("R9 retry delay ends", out_en, 1);
      do_read();
      chk("R2 all cleared", flags, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule